// File: doc/BRIEF.md
# Multi-Source XOR and Zero-Check Engine

This block is the arithmetic core of a descriptor-driven memory operation unit. A single start pulse hands it a decoded control word, a 32-bit fill pattern and a 24-bit byte count. It then produces destination words on a valid/ready output stream, or, in zero-check mode, it only inspects data. Source data comes in on a valid/ready input stream. Each word on that stream is tagged with the index of the source it belongs to.

The control word picks the operation. In block-fill mode every destination word is the fill pattern and no source is read. In the ordinary mode each destination word is the XOR of the matching word from every source; with one source this is a plain copy. In zero-check mode the XOR is computed but never written out. The engine remembers instead whether any word's XOR was nonzero. When the transfer ends it emits a completion status word that holds the byte count, a completion flag and that nonzero flag. An interrupt strobe and a status write-back strobe are raised with the completion word when the control word asks for them.

Top module: `xor_zero_engine`

## Requirements
- R1: A descriptor is taken on `start` only while `busy` is low. `busy` stays high from the accepting edge until the cycle after the completion pulse. A `start` pulse seen while busy is ignored, so the completion word still carries the first descriptor's count.
- R2: The source count is control bits 6:3 plus one (1 to 16). For each word, sources are consumed in ascending index order from 0. `srcReady` is high only when `srcIdx` equals the index expected next.
- R3: With control bits 7 and 8 both clear, each destination word equals the XOR of that word position's data from all selected sources. With one source, this is a copy.
- R4: With control bit 8 set, every destination word equals `fillValue` and `srcReady` never rises. Bit 8 takes precedence over bit 7.
- R5: A descriptor processes ceil(byteCount / 4) data words. Byte count bits 23:0 are used as given.
- R6: With bit 7 set and bit 8 clear, no destination word is produced. Completion bit 30 is set exactly when some word's XOR across the sources was nonzero. The flag is sticky within a descriptor and clears when the next descriptor is accepted.
- R7: `doneValid` is a single-cycle pulse. The completion word has bit 31 = 1, bits 23:0 = the byte count, and bits 29:24 = 0. Bit 30 is 0 unless R6 sets it.
- R8: A byte count of zero completes with no source or destination traffic. Its completion word is 0x80000000.
- R9: `irq` pulses with `doneValid` exactly when control bit 0 is set. `statusWrite` pulses with `doneValid` exactly when control bit 12 is set. Control bits 2:1 (direction) do not change any output.
- R10: While `dstValid` is high and `dstReady` is low, `dstValid` stays high and `dstData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Descriptor strobe |
| ctrlWord | input | 32 | Decoded descriptor control word |
| fillValue | input | 32 | Block-fill pattern |
| byteCount | input | 24 | Transfer length in bytes |
| busy | output | 1 | Descriptor in progress |
| srcValid | input | 1 | Source word offered |
| srcReady | output | 1 | Source word accepted this cycle |
| srcIdx | input | 4 | Source index tag of the offered word |
| srcData | input | 32 | Source data word |
| dstValid | output | 1 | Destination word offered |
| dstReady | input | 1 | Destination sink ready |
| dstData | output | 32 | Destination data word |
| doneValid | output | 1 | Completion pulse |
| doneWord | output | 32 | Completion status word |
| irq | output | 1 | Interrupt strobe |
| statusWrite | output | 1 | Status write-back strobe |

## Verification
The hardest case to reach from the ports is a nonzero flag that must survive later all-zero words and then vanish on the next descriptor. The bench shapes the source data so that every word's XOR cancels, except for one chosen word where a single bit is flipped. It sweeps that word and the source count from 1 to 16, and runs the sweep back to back so that each flagged descriptor is followed by clean ones. Out-of-order source tags are offered ahead of the correct one. An extra start pulse is issued mid-transfer to show it is ignored.

// File: rtl/xorz_pkg.sv
package xorz_pkg;
  localparam int CTL_INT_BIT  = 0;
  localparam int CTL_SRC_LSB  = 3;
  localparam int CTL_ZERO_BIT = 7;
  localparam int CTL_FILL_BIT = 8;
  localparam int CTL_WB_BIT   = 12;

  typedef struct packed {
    logic loadDesc;
    logic clrAcc;
    logic accEn;
    logic zeroUpd;
    logic selFill;
  } xorz_strobe_t;
endpackage

// File: rtl/xorz_ctrl.sv
module xorz_ctrl
  import xorz_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 24,
  parameter int SRC_MAX = 16,
  localparam int SRC_W      = $clog2(SRC_MAX),
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int WB_SH      = $clog2(WORD_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DATA_W-1:0] ctrlWord,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             srcValid,
  input  logic [SRC_W-1:0] srcIdx,
  input  logic             dstReady,
  output logic             srcReady,
  output logic             dstValid,
  output logic             busy,
  output logic             doneValid,
  output logic             irq,
  output logic             statusWrite,
  output xorz_strobe_t     strobe
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EMIT, S_DONE} state_t;

  state_t           state;
  logic [SRC_W-1:0] srcCnt, srcLast;
  logic [CNT_W-1:0] wordsLeft;
  logic             fillMode, zeroMode, intEn, wbEn;

  logic             accept, srcHs, dstHs, lastSrc;
  logic [CNT_W:0]   wordSum;
  logic [CNT_W-1:0] wordsIn;

  assign wordSum = {1'b0, byteCount} + (CNT_W+1)'(WORD_BYTES - 1);
  assign wordsIn = CNT_W'(wordSum >> WB_SH);

  assign accept   = start && (state == S_IDLE);
  assign srcReady = (state == S_FETCH) && (srcIdx == srcCnt);
  assign dstValid = (state == S_EMIT);
  assign srcHs    = srcValid && srcReady;
  assign dstHs    = dstValid && dstReady;
  assign lastSrc  = (srcCnt == srcLast);

  assign busy        = (state != S_IDLE);
  assign doneValid   = (state == S_DONE);
  assign irq         = doneValid && intEn;
  assign statusWrite = doneValid && wbEn;

  always_comb begin
    strobe.loadDesc = accept;
    strobe.clrAcc   = accept || (dstHs && !fillMode) || (srcHs && lastSrc && zeroMode);
    strobe.accEn    = srcHs;
    strobe.zeroUpd  = srcHs && lastSrc && zeroMode;
    strobe.selFill  = fillMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      srcCnt    <= '0;
      srcLast   <= '0;
      wordsLeft <= '0;
      fillMode  <= 1'b0;
      zeroMode  <= 1'b0;
      intEn     <= 1'b0;
      wbEn      <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          srcCnt    <= '0;
          srcLast   <= ctrlWord[CTL_SRC_LSB +: SRC_W];
          wordsLeft <= wordsIn;
          fillMode  <= ctrlWord[CTL_FILL_BIT];
          zeroMode  <= ctrlWord[CTL_ZERO_BIT] && !ctrlWord[CTL_FILL_BIT];
          intEn     <= ctrlWord[CTL_INT_BIT];
          wbEn      <= ctrlWord[CTL_WB_BIT];
          if (wordsIn == '0)                 state <= S_DONE;
          else if (ctrlWord[CTL_FILL_BIT])   state <= S_EMIT;
          else                               state <= S_FETCH;
        end
        S_FETCH: if (srcHs) begin
          if (lastSrc) begin
            srcCnt <= '0;
            if (zeroMode) begin
              wordsLeft <= wordsLeft - 1'b1;
              if (wordsLeft == CNT_W'(1)) state <= S_DONE;
            end else begin
              state <= S_EMIT;
            end
          end else begin
            srcCnt <= srcCnt + 1'b1;
          end
        end
        S_EMIT: if (dstHs) begin
          wordsLeft <= wordsLeft - 1'b1;
          if (wordsLeft == CNT_W'(1)) state <= S_DONE;
          else if (!fillMode)          state <= S_FETCH;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xorz_dpath.sv
module xorz_dpath
  import xorz_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  xorz_strobe_t      strobe,
  input  logic [DATA_W-1:0] fillValue,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] dstData,
  output logic [DATA_W-1:0] doneWord
);
  logic [DATA_W-1:0] acc, accNext, fillReg;
  logic [CNT_W-1:0]  countReg;
  logic              nzFlag;

  assign accNext = acc ^ srcData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      fillReg  <= '0;
      countReg <= '0;
      nzFlag   <= 1'b0;
    end else begin
      if (strobe.clrAcc)     acc <= '0;
      else if (strobe.accEn) acc <= accNext;
      if (strobe.loadDesc) begin
        fillReg  <= fillValue;
        countReg <= byteCount;
        nzFlag   <= 1'b0;
      end else if (strobe.zeroUpd && (accNext != '0)) begin
        nzFlag <= 1'b1;
      end
    end
  end

  assign dstData = strobe.selFill ? fillReg : acc;

  always_comb begin
    doneWord              = '0;
    doneWord[CNT_W-1:0]   = countReg;
    doneWord[DATA_W-1]    = 1'b1;
    doneWord[DATA_W-2]    = nzFlag;
  end
endmodule

// File: rtl/xor_zero_engine.sv
module xor_zero_engine
  import xorz_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 24,
  parameter int SRC_MAX = 16,
  localparam int SRC_W  = $clog2(SRC_MAX)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] ctrlWord,
  input  logic [DATA_W-1:0] fillValue,
  input  logic [CNT_W-1:0]  byteCount,
  output logic              busy,
  input  logic              srcValid,
  output logic              srcReady,
  input  logic [SRC_W-1:0]  srcIdx,
  input  logic [DATA_W-1:0] srcData,
  output logic              dstValid,
  input  logic              dstReady,
  output logic [DATA_W-1:0] dstData,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneWord,
  output logic              irq,
  output logic              statusWrite
);
  xorz_strobe_t strobe;

  xorz_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SRC_MAX(SRC_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ctrlWord(ctrlWord),
    .byteCount(byteCount), .srcValid(srcValid), .srcIdx(srcIdx),
    .dstReady(dstReady), .srcReady(srcReady), .dstValid(dstValid),
    .busy(busy), .doneValid(doneValid), .irq(irq),
    .statusWrite(statusWrite), .strobe(strobe)
  );

  xorz_dpath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fillValue(fillValue),
    .byteCount(byteCount), .srcData(srcData), .dstData(dstData),
    .doneWord(doneWord)
  );
endmodule

// File: rtl/xorz_checker.sv
module xorz_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              srcReady,
  input logic              dstValid,
  input logic              dstReady,
  input logic [DATA_W-1:0] dstData,
  input logic              doneValid,
  input logic [DATA_W-1:0] doneWord,
  input logic              irq,
  input logic              statusWrite
);
  a_r7_done_complete: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> doneWord[DATA_W-1]);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  a_r1_done_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !busy);
  a_r9_irq_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (irq || statusWrite) |-> doneValid);
  a_r10_dst_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dstValid && !dstReady) |=> (dstValid && $stable(dstData)));
  a_r2_ready_busy: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> (busy && !dstValid));
endmodule

bind xor_zero_engine xorz_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/xor_zero_engine_bench.sv
module xor_zero_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic [31:0] fillValue = '0;
  logic [23:0] byteCount = '0;
  logic        busy, srcReady, dstValid, doneValid, irq, statusWrite;
  logic        srcValid = 1'b0;
  logic [3:0]  srcIdx = '0;
  logic [31:0] srcData = '0;
  logic        dstReady = 1'b1;
  logic [31:0] dstData, doneWord;

  int errors = 0;
  int checks = 0;
  int dstHsCnt = 0;

  always #4 clk = ~clk;

  xor_zero_engine u_xor_zero_engine (.*);

  always @(posedge clk) if (dstValid && dstReady) dstHsCnt = dstHsCnt + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int seed, int w, int s);
    return (32'(seed) * 32'h9E3779B1) ^ {w[7:0], s[7:0], 16'hA5C3} ^ (32'(s + 1) << (w % 8));
  endfunction

  task automatic sendSrc(input int idx, input logic [31:0] d);
    @(negedge clk);
    srcValid = 1'b1; srcIdx = 4'(idx); srcData = d;
    #1;
    while (!srcReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    srcValid = 1'b0;
  endtask

  task automatic getDst(input logic stall, input logic expFill, output logic [31:0] d);
    @(negedge clk); #1;
    while (!dstValid) begin
      if (expFill) chk(srcReady == 1'b0, "R4 srcReady in fill", {31'b0, srcReady}, 32'h0);
      @(negedge clk); #1;
    end
    if (stall) begin
      logic [31:0] held;
      held = dstData;
      dstReady = 1'b0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); #1;
        chk(dstValid && dstData == held, "R10 stall hold", dstData, held);
      end
      dstReady = 1'b1;
    end
    d = dstData;
    @(posedge clk); #1;
  endtask

  task automatic runDesc(input int nsrc, input int bytes, input logic fillEn, input logic zeroEn,
                         input logic intB, input logic wbB, input logic [1:0] dir, input int seed,
                         input int badW, input logic probe, input logic stall);
    int words;
    logic expNz;
    logic [31:0] expWord, d, acc, fillPat;
    words = (bytes + 3) / 4;
    fillPat = pat(seed, 99, 7);
    expNz = zeroEn && !fillEn && badW >= 0 && badW < words;
    @(negedge clk);
    ctrlWord = {19'b0, wbB, 3'b0, fillEn, zeroEn, 4'(nsrc - 1), dir, intB};
    fillValue = fillPat; byteCount = 24'(bytes); start = 1'b1;
    dstHsCnt = 0;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", {31'b0, busy}, 32'h1);
    if (probe) begin
      @(negedge clk);
      start = 1'b1; byteCount = 24'h000123;
      @(posedge clk); #1;
      start = 1'b0; byteCount = 24'(bytes);
    end
    for (int w = 0; w < words; w++) begin
      if (fillEn) begin
        getDst(stall, 1'b1, d);
        chk(d == fillPat, "R4 fill word", d, fillPat);
      end else begin
        acc = '0;
        for (int s = 0; s < nsrc; s++) begin
          logic [31:0] v;
          if (zeroEn && s == nsrc - 1) v = acc ^ ((w == badW) ? 32'h0000_0100 : 32'h0);
          else v = pat(seed, w, s);
          acc = acc ^ v;
          if (probe && w == 0 && s == 0) begin
            for (int k = 0; k < 3; k++) begin
              @(negedge clk);
              srcValid = 1'b1; srcIdx = 4'd1; srcData = 32'hDEAD_BEEF;
              #1;
              chk(srcReady == 1'b0, "R2 wrong index refused", {31'b0, srcReady}, 32'h0);
            end
          end
          sendSrc(s, v);
        end
        if (!zeroEn) begin
          getDst(stall, 1'b0, d);
          chk(d == acc, "R3 xor word", d, acc);
        end
      end
    end
    @(negedge clk);
    while (!doneValid) @(negedge clk);
    expWord = {1'b1, expNz, 6'b0, 24'(bytes)};
    chk(doneWord == expWord, "R7 completion word", doneWord, expWord);
    chk(irq == intB, "R9 irq", {31'b0, irq}, {31'b0, intB});
    chk(statusWrite == wbB, "R9 statusWrite", {31'b0, statusWrite}, {31'b0, wbB});
    chk(dstHsCnt == ((zeroEn && !fillEn) ? 0 : words), "R5 R6 dst word count",
        32'(dstHsCnt), 32'((zeroEn && !fillEn) ? 0 : words));
    @(negedge clk);
    chk(!doneValid && !busy, "R7 single pulse", {30'b0, doneValid, busy}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(!busy && !srcReady && !dstValid && !doneValid, "R1 reset idle",
        {28'b0, busy, srcReady, dstValid, doneValid}, 32'h0);
    // R8 zero length
    runDesc(1, 0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1, -1, 1'b0, 1'b0);
    runDesc(5, 0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2, -1, 1'b0, 1'b0);
    // R3 / R9 sweep of source counts
    for (int n = 1; n <= 16; n++)
      runDesc(n, 10, 1'b0, 1'b0, n[0], n[1], 2'(n >> 1), n + 3, -1, 1'b0, 1'b0);
    // R4 fill, incl. priority over zero check, R5 rounding
    runDesc(3, 12, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 40, -1, 1'b0, 1'b0);
    runDesc(3, 1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 41, 0, 1'b0, 1'b0);
    runDesc(1, 1025, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 42, -1, 1'b0, 1'b0);
    // R6 zero-check sweep: flagged then clean descriptors back to back
    for (int n = 1; n <= 16; n++) begin
      runDesc(n, 12, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 60 + n, n % 3, 1'b0, 1'b0);
      runDesc(n, 12, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 80 + n, -1, 1'b0, 1'b0);
    end
    // R2 ordering and R1 ignored start
    runDesc(4, 8, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 90, -1, 1'b1, 1'b0);
    runDesc(1, 8, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 91, 1, 1'b1, 1'b0);
    // R10 destination stall
    runDesc(2, 8, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 92, -1, 1'b0, 1'b1);
    runDesc(1, 8, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 93, -1, 1'b0, 1'b1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule